// File: doc/BRIEF.md
# RTC Supply and Oscillator Status Register

This block is the status and control register that a real-time clock uses to watch its own supply and its crystal. It holds eight bits behind a small synchronous register bus with an address, a write strobe, write data and read data. The bits are:

- a threshold select for the supply comparator;
- a sticky low-supply flag;
- a free scratch bit;
- a sticky oscillator-stop flag;
- an active-low enable for the 32.768 kHz clock output;
- three event flags, each of which drives an active-low interrupt line.

Two asynchronous inputs are synchronised inside the block: the supply comparator output and the raw oscillator clock. A watchdog counter runs on the system clock. When it sees no rising edge of the oscillator for a set number of cycles, it declares a halt.

A halt sets the oscillator-stop flag. While that flag is set, the block acts as a soft reset for its neighbours:

- it holds every other bit of this register at zero;
- it asserts a clear line to the neighbouring adjustment and control registers;
- it holds all interrupt lines inactive;
- it forces the clock output on.

Software clears either sticky flag by writing 0 to it, and that write also re-arms the matching detector.

Top module: `rtc_pwr_stat_reg`

## Requirements
- R1: After reset the register reads 0x10: only the oscillator-stop flag is set. The bit layout from bit 7 down to bit 0 is: threshold select, low-supply flag, scratch, oscillator-stop flag, clock-out enable (active low), and event flags 2..0.
- R2: With the register address (default 0xF) on the bus, read data shows the register in the same cycle. Any other address reads 0x00, and a write to any other address changes nothing.
- R3: Bit 7 is plain read/write storage and drives the `thr_sel` output (0 selects the higher threshold, 1 the lower).
- R4: Two clocks after synchronisation, a high comparator input sets bit 6 while the monitor is enabled. Bit 6 then stays 1 after the comparator falls, and `mon_en` is low while it is 1.
- R5: Writing 0 to bit 6 clears it and raises `mon_en`, which re-arms the monitor so that a comparator still high sets the flag again. Writing 1 to bit 6 has no effect.
- R6: Bit 5 is plain read/write storage.
- R7: Bit 4 is set when the synchronised oscillator shows no rising edge for HALT_TMO system clocks. It stays 1 after oscillation resumes.
- R8: Bit 4 is cleared only by writing 0 to it, and writing 1 to it has no effect. If a halt is detected in the same cycle as a clearing write, the flag stays set.
- R9: While bit 4 is 1, the following hold:
  - every other bit reads 0;
  - `nbr_clr` is 1;
  - `irq_n` is all ones;
  - `clkout_en` is 1.
- R10: Bit 3 is plain read/write storage, and `clkout_en` is its inverse.
- R11: A high `evt_in[i]` sets event flag bit i, and writing 0 to that bit clears it. Writing 1 has no effect, and a set in the same cycle as a clearing write wins. `irq_n[i]` is low while flag i is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | ADDR_W | Register bus address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| cmp_below_a | input | 1 | Asynchronous comparator output, high when the supply is below the threshold |
| osc_clk_a | input | 1 | Asynchronous raw oscillator clock |
| evt_in | input | 3 | Event pulses that set the event flags |
| thr_sel | output | 1 | Threshold select to the comparator |
| mon_en | output | 1 | Supply monitor enable |
| nbr_clr | output | 1 | Clear to the adjustment and control registers |
| irq_n | output | 3 | Active-low interrupt outputs |
| clkout_en | output | 1 | 32.768 kHz clock output enable |

## Verification
On every cycle, the assertions check:

- that the oscillator-stop flag is sticky and that a write of 1 cannot set it;
- that a halt always sets the flag;
- that the other bits stay zero while the flag is set;
- that the low-supply flag is sticky and only rises after a synchronised comparator high;
- that event pulses reach their flags;
- that the output pins are masked during a halt.

Only the bench scenarios can show the end-to-end behaviour through the synchronisers and the watchdog window: the halt appearing after the oscillator stops, the flag surviving the oscillator's restart, and the monitor re-arming under a comparator that is still high. The same holds for the exact read-back values under mixed random bus traffic.

// File: rtl/rtc_pfs_pkg.sv
`timescale 1ns/1ps
package rtc_pfs_pkg;
  localparam int REG_W = 8;
  localparam int N_EVT = 3;
  localparam logic [REG_W-1:0] RST_VAL = 8'h10;

  typedef struct packed {
    logic             thr;    // threshold select
    logic             lv;     // sticky low-supply flag
    logic             scr;    // scratch
    logic             stop;   // sticky oscillator-stop flag
    logic             clk_n;  // clock-out enable, active low
    logic [N_EVT-1:0] evt;    // event flags
  } pfs_reg_t;
endpackage

// File: rtl/rtc_pfs_sync.sv
`timescale 1ns/1ps
module rtc_pfs_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_a,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_a;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/rtc_pfs_halt_wd.sv
`timescale 1ns/1ps
module rtc_pfs_halt_wd #(
  parameter int TMO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_s,
  output logic halt
);
  localparam int CW = $clog2(TMO + 1);
  localparam logic [CW-1:0] TMO_C = CW'(TMO);

  logic          osc_d_q;
  logic          rise;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign rise = osc_s & ~osc_d_q;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (rise) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (cnt_q != TMO_C) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      osc_d_q <= 1'b0;
    end else begin
      osc_d_q <= osc_s;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign halt = (cnt_q == TMO_C);

  // R7: an oscillator edge always withdraws the halt
  a_r7_edge_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !halt);
  // R7: without an edge a declared halt persists
  a_r7_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !rise) |=> halt);
endmodule

// File: rtl/rtc_pfs_core.sv
`timescale 1ns/1ps
module rtc_pfs_core
  import rtc_pfs_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'hF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              cmp_s,
  input  logic              halt,
  input  logic [N_EVT-1:0]  evt_in,
  output pfs_reg_t          reg_o,
  output logic              mon_en
);
  pfs_reg_t r_q;
  pfs_reg_t r_d;
  pfs_reg_t w;
  logic     sel;
  logic     wr_hit;
  logic     lv_set;
  logic     r_en;

  assign w      = pfs_reg_t'(wdata);
  assign sel    = (addr == REG_ADDR);
  assign wr_hit = we & sel;
  assign mon_en = ~r_q.lv;
  assign lv_set = cmp_s & mon_en;

  always_comb begin
    r_d = r_q;
    if (wr_hit) begin
      r_d.thr   = w.thr;
      r_d.scr   = w.scr;
      r_d.clk_n = w.clk_n;
      if (!w.lv)   r_d.lv   = 1'b0;
      if (!w.stop) r_d.stop = 1'b0;
      r_d.evt = r_q.evt & w.evt;
    end
    // hardware sets take priority over clearing writes
    if (lv_set) r_d.lv = 1'b1;
    r_d.evt = r_d.evt | evt_in;
    if (halt) r_d.stop = 1'b1;
    // a set stop flag holds every other bit at zero
    if (r_d.stop) begin
      r_d      = '0;
      r_d.stop = 1'b1;
    end
  end

  assign r_en = wr_hit | lv_set | (|evt_in) | halt | r_q.stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_q <= pfs_reg_t'(RST_VAL);
    else if (r_en) r_q <= r_d;
  end

  assign rdata = sel ? REG_W'(r_q) : '0;
  assign reg_o = r_q;

  // R8: stop flag survives unless a zero is written to it
  a_r8_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (r_q.stop && !(wr_hit && !w.stop)) |=> r_q.stop);
  // R8: writing one cannot set the stop flag
  a_r8_wr1_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_q.stop && !halt && wr_hit && w.stop) |=> !r_q.stop);
  // R7: a declared halt sets the flag
  a_r7_halt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> r_q.stop);
  // R9: other bits zero while stop is set
  a_r9_others_zero: assert property (@(posedge clk) disable iff (!rst_n)
    r_q.stop |-> ((REG_W'(r_q) & ~RST_VAL) == '0));
  // R5: low-supply flag sticky without a write or halt
  a_r5_lv_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (r_q.lv && !wr_hit && !halt) |=> r_q.lv);
  // R4: low-supply flag only rises after a synchronised comparator high
  a_r4_lv_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_q.lv) |-> $past(cmp_s));
  // R11: event pulses reach their flags
  a_r11_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((|evt_in) && !halt && !r_q.stop) |=> ((r_q.evt & $past(evt_in)) == $past(evt_in)));
endmodule

// File: rtl/rtc_pwr_stat_reg.sv
`timescale 1ns/1ps
module rtc_pwr_stat_reg
  import rtc_pfs_pkg::*;
#(
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'hF,
  parameter int                HALT_TMO = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              cmp_below_a,
  input  logic              osc_clk_a,
  input  logic [2:0]        evt_in,
  output logic              thr_sel,
  output logic              mon_en,
  output logic              nbr_clr,
  output logic [2:0]        irq_n,
  output logic              clkout_en
);
  logic [1:0] sync_q;
  logic       halt;
  pfs_reg_t   r;

  rtc_pfs_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_a   ({cmp_below_a, osc_clk_a}),
    .q     (sync_q)
  );

  rtc_pfs_halt_wd #(.TMO(HALT_TMO)) u_wd (
    .clk   (clk),
    .rst_n (rst_n),
    .osc_s (sync_q[0]),
    .halt  (halt)
  );

  rtc_pfs_core #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (bus_addr),
    .we     (bus_we),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .cmp_s  (sync_q[1]),
    .halt   (halt),
    .evt_in (evt_in),
    .reg_o  (r),
    .mon_en (mon_en)
  );

  assign thr_sel   = r.thr;
  assign nbr_clr   = r.stop;
  assign irq_n     = ~(r.evt & {N_EVT{~r.stop}});
  assign clkout_en = ~r.clk_n | r.stop;

  // R9: pins masked while neighbours are held cleared
  a_r9_pins_masked: assert property (@(posedge clk) disable iff (!rst_n)
    nbr_clr |-> (irq_n == 3'b111 && clkout_en && !thr_sel));
endmodule

// File: tb/sim_rtc_pwr_stat_reg.sv
`timescale 1ns/1ps
module sim_rtc_pwr_stat_reg;
  localparam logic [3:0] RA = 4'hF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       cmp_below_a;
  logic       osc_clk_a;
  logic [2:0] evt_in;
  logic       thr_sel, mon_en, nbr_clr, clkout_en;
  logic [2:0] irq_n;
  logic       osc_run = 1'b1;
  logic [7:0] model;
  int         total = 0;
  int         bad = 0;

  rtc_pwr_stat_reg u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_below_a(cmp_below_a),
    .osc_clk_a(osc_clk_a), .evt_in(evt_in), .thr_sel(thr_sel), .mon_en(mon_en),
    .nbr_clr(nbr_clr), .irq_n(irq_n), .clkout_en(clkout_en)
  );

  always #4 clk = ~clk;

  initial begin
    osc_clk_a = 1'b0;
    forever begin
      #20;
      if (osc_run) osc_clk_a = ~osc_clk_a;
    end
  end

  // expected pins from a register value: {rdata, irq_n, clkout_en, thr_sel, mon_en, nbr_clr}
  function automatic logic [14:0] pins(input logic [7:0] r);
    return {r, ~(r[2:0] & {3{~r[4]}}), ~r[3] | r[4], r[7], ~r[6], r[4]};
  endfunction

  function automatic logic [7:0] nxt(input logic [7:0] cur, input logic hit,
                                     input logic [7:0] wd, input logic [2:0] ev,
                                     input logic lvs, input logic hlt);
    logic [7:0] n;
    n = cur;
    if (hit) begin
      n[7] = wd[7]; n[5] = wd[5]; n[3] = wd[3];
      if (!wd[6]) n[6] = 1'b0;
      if (!wd[4]) n[4] = 1'b0;
      n[2:0] = cur[2:0] & wd[2:0];
    end
    if (lvs) n[6] = 1'b1;
    n[2:0] = n[2:0] | ev;
    if (hlt) n[4] = 1'b1;
    if (n[4]) n = 8'h10;
    return n;
  endfunction

  task automatic chk(input string req, input logic [14:0] act, input logic [14:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [14:0] now_pins();
    return {bus_rdata, irq_n, clkout_en, thr_sel, mon_en, nbr_clr};
  endfunction

  // one bus cycle, then read back with the register address
  task automatic step(input logic [3:0] a, input logic w, input logic [7:0] d, input logic [2:0] ev);
    @(negedge clk);
    bus_addr = a; bus_we = w; bus_wdata = d; evt_in = ev;
    @(negedge clk);
    bus_we = 1'b0; evt_in = '0; bus_addr = RA;
    #1;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] ra;
    logic       rw;
    logic [7:0] rd;
    logic [2:0] re;
    void'($urandom(32'd20240613));
    bus_addr = RA; bus_we = 1'b0; bus_wdata = '0; cmp_below_a = 1'b0; evt_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    model = 8'h10;
    chk("R1 reset value", now_pins(), pins(model));

    step(RA, 1'b1, 8'hB8, 3'b000); model = nxt(model, 1, 8'hB8, 0, 0, 0);
    chk("R9 others held while stop", now_pins(), pins(model));
    step(RA, 1'b1, 8'h20, 3'b000); model = nxt(model, 1, 8'h20, 0, 0, 0);
    chk("R8 write0 clears stop / R6 scratch", now_pins(), pins(8'h20));
    step(RA, 1'b1, 8'hA0, 3'b000); model = nxt(model, 1, 8'hA0, 0, 0, 0);
    chk("R3 threshold select", now_pins(), pins(8'hA0));
    step(RA, 1'b1, 8'hA8, 3'b000); model = nxt(model, 1, 8'hA8, 0, 0, 0);
    chk("R10 clock-out disabled", now_pins(), pins(8'hA8));
    step(RA, 1'b0, 8'h00, 3'b101); model = nxt(model, 0, 0, 3'b101, 0, 0);
    chk("R11 event set and irq", now_pins(), pins(8'hAD));
    step(RA, 1'b1, 8'hAF, 3'b000); model = nxt(model, 1, 8'hAF, 0, 0, 0);
    chk("R11 write1 no effect", now_pins(), pins(8'hAD));
    step(RA, 1'b1, 8'hA8, 3'b001); model = nxt(model, 1, 8'hA8, 3'b001, 0, 0);
    chk("R11 set beats clear", now_pins(), pins(8'hA9));
    step(4'h3, 1'b1, 8'h00, 3'b000);
    chk("R2 other address write ignored", now_pins(), pins(8'hA9));
    bus_addr = 4'h3; #1;
    chk("R2 other address reads zero", {7'd0, bus_rdata}, 15'd0);
    bus_addr = RA; #1;

    // comparator path
    @(negedge clk); cmp_below_a = 1'b1;
    wait_cyc(5); model = model | 8'h40;
    chk("R4 low-supply set, monitor off", now_pins(), pins(model));
    @(negedge clk); cmp_below_a = 1'b0;
    wait_cyc(5);
    chk("R4 low-supply sticky", now_pins(), pins(model));
    step(RA, 1'b1, model, 3'b000);
    chk("R5 write1 no effect", now_pins(), pins(model));
    step(RA, 1'b1, model & 8'hBF, 3'b000); model = model & 8'hBF;
    chk("R5 write0 clears, monitor on", now_pins(), pins(model));
    @(negedge clk); cmp_below_a = 1'b1;
    wait_cyc(5); model = model | 8'h40;
    step(RA, 1'b1, model & 8'hBF, 3'b000);
    chk("R5 cleared under high comparator", now_pins(), pins(model & 8'hBF));
    wait_cyc(1);
    chk("R5 monitor re-armed sets again", now_pins(), pins(model));
    @(negedge clk); cmp_below_a = 1'b0;
    wait_cyc(4);
    step(RA, 1'b1, 8'h00, 3'b000); model = 8'h00;
    chk("R5 clear after test", now_pins(), pins(model));

    // random traffic, oscillator running, comparator low
    for (int i = 0; i < 300; i++) begin
      ra = ($urandom_range(0, 2) == 0) ? 4'($urandom_range(0, 15)) : RA;
      rw = 1'($urandom_range(0, 1));
      rd = 8'($urandom);
      re = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
      step(ra, rw, rd, re);
      model = nxt(model, rw && (ra == RA), rd, re, 0, 0);
      chk("R2 R3 R6 R10 R11 random traffic", now_pins(), pins(model));
    end

    // oscillator halt
    step(RA, 1'b1, 8'h20, 3'b111); model = 8'h27;
    chk("R11 setup before halt", now_pins(), pins(model));
    osc_run = 1'b0;
    wait_cyc(8);
    chk("R7 no halt before timeout", now_pins(), pins(model));
    wait_cyc(40);
    chk("R7 R9 halt sets stop and masks", now_pins(), pins(8'h10));
    step(RA, 1'b1, 8'h00, 3'b000);
    chk("R8 halt beats clearing write", now_pins(), pins(8'h10));
    osc_run = 1'b1;
    wait_cyc(30);
    chk("R7 stop sticky after resume", now_pins(), pins(8'h10));
    step(RA, 1'b1, 8'h00, 3'b000);
    chk("R8 write0 clears stop", now_pins(), pins(8'h00));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule